// File: doc/BRIEF.md
# LVDS Pair State Controller

This block sits between the pixel pipeline of a two-channel flat-panel LVDS transmitter and its analog line drivers. It decides what each of the ten differential pairs does. Each channel has four data pairs and one clock pair. For every pair the block produces a parallel word for the serializer, an output-enable (tri-state) control, a power-down control, and a flag that parks both pins at the common-mode level.

A global port enable turns the whole interface on or off. A 3-bit selector for each channel picks one of five pair states. A single/dual channel mode marks the second channel as unused when only one channel is in service, and a configuration bit chooses how unused pairs behave: powered down, or powered and held at a constant 0. In the send-zeros state the color bits are blanked, while the sync/enable timing bits and the clock pair keep running.

All decisions and all pixel bits pass through one register stage clocked by the pixel clock. A change of state therefore lands on a whole-pixel boundary, together with the pixel word sampled in the same cycle.

Top module: `lvds_pair_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, every pair after that edge has power-down 1, output-enable 0, common-mode 0 and an all-zero data word.
- R2: When `port_en` was 0 at the previous edge, every pair of both channels is in the powered-down tri-state condition (power-down 1, output-enable 0, common-mode 0, data 0), whatever the selectors and mode are.
- R3: Selector code 0 gives powered-down tri-state (power-down 1, output-enable 0). Code 1 gives powered-down zero volts (power-down 1, output-enable 1). In both cases common-mode is 0 and all five data words of the channel are 0.
- R4: Selector code 2 gives common mode on all five pairs of the channel: power-down 0, output-enable 1, common-mode 1, data 0.
- R5: Selector code 3 (send zeros) powers the channel's pairs up (power-down 0, output-enable 1, common-mode 0). It forces the 24 color bits to 0. It passes the 3 timing bits at channel-word positions 24..26 (pair 3, bits 3..5) and passes the 7-bit clock pattern on the clock pair (pair 4).
- R6: Selector code 4 (active) powers the pairs up. The data pairs carry the 28-bit channel word {0, timing[2:0], color[23:0]}, pair k taking bits 7k+6..7k, and the clock pair carries the clock pattern. Word bit 27 is always 0.
- R7: Selector codes 5, 6 and 7 behave exactly as code 0.
- R8: With `port_en` 1 and `dual_mode` 0, channel B ignores its selector. If `idle_hold_zero` is 1, all five of its pairs are powered with constant 0 data, including the clock pair (power-down 0, output-enable 1, common-mode 0). If `idle_hold_zero` is 0, they are powered-down tri-state. Channel A follows its own selector.
- R9: Every output reflects the inputs sampled at the previous rising edge, with one cycle of latency. A state change and the pixel word of the same cycle take effect together on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Global enable for the whole interface |
| dual_mode | input | 1 | 1 = both channels in use, 0 = channel A only |
| idle_hold_zero | input | 1 | Unused pairs: 1 = powered with 0 output, 0 = powered down |
| chan_state | input | 6 | Pair-state selector, bits 2:0 channel A, bits 5:3 channel B |
| chan_color | input | 48 | Color bits, 23:0 channel A, 47:24 channel B |
| chan_timing | input | 6 | Sync/enable bits, 2:0 channel A, 5:3 channel B |
| clk_pattern | input | 7 | Parallel word for both clock pairs |
| pair_data | output | 70 | Data word per pair, pair p at bits 7p+6..7p (pairs 0-4 channel A, 5-9 channel B) |
| pair_oe | output | 10 | Output-enable per pair |
| pair_pd | output | 10 | Power-down per pair |
| pair_cm | output | 10 | Common-mode level request per pair |

## Verification
The case that matters most is a selector change in the same cycle as a new pixel word. One edge must then both switch a channel between send zeros and active and present a word whose color bits differ from the one before. The bench drives fresh random pixel data on every cycle while swapping channel A between codes 3 and 4, with channel B in the opposite phase, and it toggles the port enable in the middle of that run. A behavioural model pairs each output with the selector and pixel inputs of the same earlier cycle. Any skew between the state path and the data path is therefore a miscompare on the color bits of one channel.

// File: rtl/lvds_pair_pkg.sv
package lvds_pair_pkg;

    typedef enum logic [2:0] {
        PS_PD_TRI     = 3'd0,
        PS_PD_ZERO    = 3'd1,
        PS_COMMON     = 3'd2,
        PS_SEND_ZEROS = 3'd3,
        PS_ACTIVE     = 3'd4,
        PS_HOLD_LOW   = 3'd5
    } pair_state_e;

    typedef struct packed {
        logic pd;
        logic oe;
        logic cm;
    } pair_ctl_t;

    // Selector code to state; undefined codes fall back to the safest state.
    function automatic pair_state_e decode_sel(input logic [2:0] code);
        case (code)
            3'd1:    return PS_PD_ZERO;
            3'd2:    return PS_COMMON;
            3'd3:    return PS_SEND_ZEROS;
            3'd4:    return PS_ACTIVE;
            default: return PS_PD_TRI;
        endcase
    endfunction

    // Effective channel state from enable, usage and selector.
    function automatic pair_state_e resolve_state(input logic enable,
                                                  input logic in_use,
                                                  input logic hold_low,
                                                  input logic [2:0] code);
        if (!enable)
            return PS_PD_TRI;
        if (!in_use)
            return hold_low ? PS_HOLD_LOW : PS_PD_TRI;
        return decode_sel(code);
    endfunction

    function automatic pair_ctl_t ctl_of(input pair_state_e st);
        pair_ctl_t c;
        case (st)
            PS_PD_TRI:  c = '{pd: 1'b1, oe: 1'b0, cm: 1'b0};
            PS_PD_ZERO: c = '{pd: 1'b1, oe: 1'b1, cm: 1'b0};
            PS_COMMON:  c = '{pd: 1'b0, oe: 1'b1, cm: 1'b1};
            default:    c = '{pd: 1'b0, oe: 1'b1, cm: 1'b0};
        endcase
        return c;
    endfunction

    // Bits of data pair 'pair' that hold color and are blanked in send zeros.
    function automatic logic [31:0] color_mask(input int pair,
                                               input int ser_w,
                                               input int color_w);
        logic [31:0] m;
        m = '0;
        for (int b = 0; b < ser_w; b++) begin
            if (pair * ser_w + b < color_w)
                m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/lvds_pair_drive.sv
module lvds_pair_drive
    import lvds_pair_pkg::*;
#(
    parameter int              SER_W      = 7,
    parameter logic [SER_W-1:0] BLANK_MASK = '0
) (
    input  pair_state_e        state,
    input  logic [SER_W-1:0]   src,
    output logic [SER_W-1:0]   data,
    output logic               oe,
    output logic               pd,
    output logic               cm
);

    pair_ctl_t ctl;

    always_comb begin
        ctl = ctl_of(state);
        case (state)
            PS_ACTIVE:     data = src;
            PS_SEND_ZEROS: data = src & ~BLANK_MASK;
            default:       data = '0;
        endcase
        oe = ctl.oe;
        pd = ctl.pd;
        cm = ctl.cm;
    end

endmodule

// File: rtl/lvds_chan_ctrl.sv
module lvds_chan_ctrl
    import lvds_pair_pkg::*;
#(
    parameter int SER_W      = 7,
    parameter int DATA_PAIRS = 4,
    parameter int COLOR_W    = 24,
    parameter int TIM_W      = 3,
    parameter bit IS_PRIMARY = 1'b1,
    localparam int PPC       = DATA_PAIRS + 1,
    localparam int WORD_W    = DATA_PAIRS * SER_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 port_en,
    input  logic                 dual_mode,
    input  logic                 idle_hold_zero,
    input  logic [2:0]           sel,
    input  logic [COLOR_W-1:0]   color,
    input  logic [TIM_W-1:0]     timing,
    input  logic [SER_W-1:0]     clk_pattern,
    output logic [PPC*SER_W-1:0] data,
    output logic [PPC-1:0]       oe,
    output logic [PPC-1:0]       pd,
    output logic [PPC-1:0]       cm
);

    logic              in_use;
    pair_state_e       state_d, state_q;
    logic [WORD_W-1:0] word_d, word_q;
    logic [SER_W-1:0]  pattern_q;

    assign in_use = IS_PRIMARY || dual_mode;

    always_comb begin
        state_d = resolve_state(port_en, in_use, idle_hold_zero, sel);
        word_d  = '0;
        word_d[COLOR_W-1:0]    = color;
        word_d[COLOR_W+:TIM_W] = timing;
    end

    // One register stage: state and pixel word move on the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PS_PD_TRI;
            word_q    <= '0;
            pattern_q <= '0;
        end else begin
            state_q   <= state_d;
            word_q    <= word_d;
            pattern_q <= clk_pattern;
        end
    end

    for (genvar k = 0; k < PPC; k++) begin : g_pair
        if (k < DATA_PAIRS) begin : g_data
            localparam logic [31:0] MASK32 = color_mask(k, SER_W, COLOR_W);
            lvds_pair_drive #(
                .SER_W      (SER_W),
                .BLANK_MASK (MASK32[SER_W-1:0])
            ) drv_i (
                .state (state_q),
                .src   (word_q[k*SER_W+:SER_W]),
                .data  (data[k*SER_W+:SER_W]),
                .oe    (oe[k]),
                .pd    (pd[k]),
                .cm    (cm[k])
            );
        end else begin : g_clock
            lvds_pair_drive #(
                .SER_W      (SER_W),
                .BLANK_MASK ('0)
            ) drv_i (
                .state (state_q),
                .src   (pattern_q),
                .data  (data[k*SER_W+:SER_W]),
                .oe    (oe[k]),
                .pd    (pd[k]),
                .cm    (cm[k])
            );
        end
    end

    // R2: a disabled port leaves every pair powered down and tri-stated.
    p_port_off_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(port_en)) |-> (&pd && !(|oe) && data == '0));

    // R5: send zeros blanks color, keeps timing and clock running.
    p_blank_color_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(port_en) && (IS_PRIMARY || $past(dual_mode))
         && $past(sel) == 3'd3)
        |-> (data[COLOR_W-1:0] == '0
             && data[COLOR_W+:TIM_W] == $past(timing)
             && data[DATA_PAIRS*SER_W+:SER_W] == $past(clk_pattern)));

    // R6: active passes color of the previous cycle unchanged.
    p_active_pass_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(port_en) && (IS_PRIMARY || $past(dual_mode))
         && $past(sel) == 3'd4)
        |-> (data[COLOR_W-1:0] == $past(color) && !(|pd) && &oe));

    // R7: undefined selector codes behave as powered-down tri-state.
    p_bad_code_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (IS_PRIMARY || $past(dual_mode)) && $past(sel) > 3'd4)
        |-> (&pd && !(|oe) && !(|cm)));

    // R8: an unused channel held low stays powered with zero output.
    p_unused_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!IS_PRIMARY && !$past(rst) && $past(port_en) && !$past(dual_mode)
         && $past(idle_hold_zero))
        |-> (data == '0 && &oe && !(|pd) && !(|cm)));

endmodule

// File: rtl/lvds_pair_ctrl.sv
module lvds_pair_ctrl
    import lvds_pair_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter int SER_W      = 7,
    parameter int DATA_PAIRS = 4,
    parameter int COLOR_W    = 24,
    parameter int TIM_W      = 3,
    localparam int PPC       = DATA_PAIRS + 1,
    localparam int NUM_PAIRS = NUM_CH * PPC
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       port_en,
    input  logic                       dual_mode,
    input  logic                       idle_hold_zero,
    input  logic [NUM_CH*3-1:0]        chan_state,
    input  logic [NUM_CH*COLOR_W-1:0]  chan_color,
    input  logic [NUM_CH*TIM_W-1:0]    chan_timing,
    input  logic [SER_W-1:0]           clk_pattern,
    output logic [NUM_PAIRS*SER_W-1:0] pair_data,
    output logic [NUM_PAIRS-1:0]       pair_oe,
    output logic [NUM_PAIRS-1:0]       pair_pd,
    output logic [NUM_PAIRS-1:0]       pair_cm
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        lvds_chan_ctrl #(
            .SER_W      (SER_W),
            .DATA_PAIRS (DATA_PAIRS),
            .COLOR_W    (COLOR_W),
            .TIM_W      (TIM_W),
            .IS_PRIMARY (ch == 0)
        ) chan_i (
            .clk            (clk),
            .rst            (rst),
            .port_en        (port_en),
            .dual_mode      (dual_mode),
            .idle_hold_zero (idle_hold_zero),
            .sel            (chan_state[ch*3+:3]),
            .color          (chan_color[ch*COLOR_W+:COLOR_W]),
            .timing         (chan_timing[ch*TIM_W+:TIM_W]),
            .clk_pattern    (clk_pattern),
            .data           (pair_data[ch*PPC*SER_W+:PPC*SER_W]),
            .oe             (pair_oe[ch*PPC+:PPC]),
            .pd             (pair_pd[ch*PPC+:PPC]),
            .cm             (pair_cm[ch*PPC+:PPC])
        );
    end

    // R1: the edge after reset leaves every pair powered down and silent.
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (&pair_pd && !(|pair_oe) && !(|pair_cm) && pair_data == '0));

    // R4: a common-mode pair is never powered down nor tri-stated.
    p_cm_live_r4: assert property (@(posedge clk) disable iff (rst)
        ((pair_cm & pair_pd) == '0 && (pair_cm & ~pair_oe) == '0));

endmodule

// File: tb/lvds_pair_ctrl_tb_top.sv
module lvds_pair_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        port_en;
    logic        dual_mode;
    logic        idle_hold_zero;
    logic [5:0]  chan_state;
    logic [47:0] chan_color;
    logic [5:0]  chan_timing;
    logic [6:0]  clk_pattern;
    logic [69:0] pair_data;
    logic [9:0]  pair_oe, pair_pd, pair_cm;

    logic [69:0] exp_data;
    logic [9:0]  exp_oe, exp_pd, exp_cm;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    lvds_pair_ctrl dut_i (
        .clk            (clk),
        .rst            (rst),
        .port_en        (port_en),
        .dual_mode      (dual_mode),
        .idle_hold_zero (idle_hold_zero),
        .chan_state     (chan_state),
        .chan_color     (chan_color),
        .chan_timing    (chan_timing),
        .clk_pattern    (clk_pattern),
        .pair_data      (pair_data),
        .pair_oe        (pair_oe),
        .pair_pd        (pair_pd),
        .pair_cm        (pair_cm)
    );

    // Behavioural model: mode 0 tri, 1 pd-zero, 2 common, 3 send zeros,
    // 4 active, 6 powered and held low.
    task automatic model();
        exp_data = '0;
        exp_oe   = '0;
        exp_pd   = '0;
        exp_cm   = '0;
        for (int ch = 0; ch < 2; ch++) begin
            int mode;
            int code;
            code = int'(chan_state[ch*3+:3]);
            if (rst || !port_en)          mode = 0;
            else if (ch == 1 && !dual_mode) mode = idle_hold_zero ? 6 : 0;
            else if (code > 4)            mode = 0;
            else                          mode = code;
            for (int p = 0; p < 5; p++) begin
                int idx;
                idx = ch * 5 + p;
                exp_pd[idx] = (mode <= 1);
                exp_oe[idx] = (mode != 0);
                exp_cm[idx] = (mode == 2);
                for (int b = 0; b < 7; b++) begin
                    int  g;
                    logic v;
                    g = p * 7 + b;
                    v = 1'b0;
                    if (p == 4) begin
                        if (mode == 3 || mode == 4) v = clk_pattern[b];
                    end else if (g >= 24 && g < 27) begin
                        if (mode == 3 || mode == 4) v = chan_timing[ch*3 + g - 24];
                    end else if (g < 24) begin
                        if (mode == 4) v = chan_color[ch*24 + g];
                    end
                    exp_data[idx*7 + b] = v;
                end
            end
        end
    endtask

    task automatic cycle(input string tag);
        model();
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (pair_data !== exp_data || pair_oe !== exp_oe ||
            pair_pd !== exp_pd || pair_cm !== exp_cm) begin
            n_bad++;
            $display("FAIL %s data=%h exp=%h oe=%b exp=%b pd=%b exp=%b cm=%b exp=%b",
                     tag, pair_data, exp_data, pair_oe, exp_oe,
                     pair_pd, exp_pd, pair_cm, exp_cm);
        end
    endtask

    task automatic fresh_pixels();
        chan_color[31:0]  = $urandom();
        chan_color[47:32] = 16'($urandom());
        chan_timing       = 6'($urandom());
        clk_pattern       = 7'($urandom());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; port_en = 1'b1; dual_mode = 1'b1; idle_hold_zero = 1'b1;
        chan_state = {3'd4, 3'd4};
        fresh_pixels();
        @(negedge clk);
        cycle("R1 reset");
        fresh_pixels();
        cycle("R1 reset");
        rst = 1'b0;

        // R2: port disabled overrides active selectors
        port_en = 1'b0;
        for (int i = 0; i < 4; i++) begin fresh_pixels(); cycle("R2 port off"); end

        // R3: both powered-down flavours
        port_en = 1'b1;
        chan_state = {3'd1, 3'd0};
        for (int i = 0; i < 2; i++) begin fresh_pixels(); cycle("R3 pd A0 B1"); end
        chan_state = {3'd0, 3'd1};
        for (int i = 0; i < 2; i++) begin fresh_pixels(); cycle("R3 pd A1 B0"); end

        // R4: common mode
        chan_state = {3'd2, 3'd2};
        for (int i = 0; i < 3; i++) begin fresh_pixels(); cycle("R4 common"); end

        // R5: send zeros with random pixels, then all ones
        chan_state = {3'd3, 3'd3};
        for (int i = 0; i < 5; i++) begin fresh_pixels(); cycle("R5 send zeros"); end
        chan_color = '1; chan_timing = '1; clk_pattern = 7'b1100011;
        cycle("R5 send zeros ones");

        // R6: active, with edge patterns
        chan_state = {3'd4, 3'd4};
        chan_color = '1; chan_timing = '1; clk_pattern = '1;
        cycle("R6 active ones");
        chan_color = '0; chan_timing = '0; clk_pattern = '0;
        cycle("R6 active zeros");
        for (int i = 0; i < 5; i++) begin fresh_pixels(); cycle("R6 active"); end

        // R7: undefined codes on channel A, B stays active
        for (int c = 5; c < 8; c++) begin
            chan_state = {3'd4, 3'(c)};
            fresh_pixels();
            cycle("R7 bad code");
        end
        chan_state = {3'(7), 3'd4};
        fresh_pixels();
        cycle("R7 bad code B");

        // R8: single-channel mode, both idle behaviours
        dual_mode = 1'b0;
        idle_hold_zero = 1'b1;
        chan_state = {3'd4, 3'd4};
        for (int i = 0; i < 3; i++) begin fresh_pixels(); cycle("R8 idle hold low"); end
        chan_state = {3'd2, 3'd3};
        fresh_pixels();
        cycle("R8 idle hold low sel ignored");
        idle_hold_zero = 1'b0;
        chan_state = {3'd1, 3'd4};
        for (int i = 0; i < 3; i++) begin fresh_pixels(); cycle("R8 idle powered down"); end

        // R9: state and pixel word change together every cycle
        dual_mode = 1'b1;
        idle_hold_zero = 1'b1;
        for (int i = 0; i < 12; i++) begin
            chan_state = (i % 2 == 0) ? {3'd4, 3'd3} : {3'd3, 3'd4};
            port_en    = (i != 5);
            dual_mode  = (i != 8);
            fresh_pixels();
            cycle("R9 same-cycle switch");
        end
        port_en = 1'b1;
        dual_mode = 1'b1;
        chan_state = {3'd4, 3'd4};
        fresh_pixels();
        cycle("R9 settle");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule